// File: doc/BRIEF.md
# Transfer Descriptor Transaction Sequencer

This block executes one bulk or interrupt transfer descriptor for a USB host as a chain of bus transactions. After a descriptor is loaded (token word, starting offset inside the first page, a list of buffer page frame numbers, the endpoint's maximum packet size and the direction), the block issues one transaction request at a time. Each request carries a 32-bit buffer address and a byte length. The block waits for the completion of each request and then updates its progress state: the remaining byte count, the page index, the in-page offset and the data toggle.

The transfer ends when the remaining count reaches zero or when an IN transaction returns a short packet. At that point the block drops its active flag and shows the updated token word. If the descriptor asked for it, the block also holds a completion interrupt pending until the next interrupt threshold tick. A descriptor whose byte count or page index is out of range is refused with a one-cycle error pulse.

Top module: `td_xfer_seq`

## Requirements
- R1: Token fields are: data toggle in bit 31, byte count in bits 30:16, interrupt-on-complete in bit 15 and page index in bits 14:12. `token_out` uses the same layout from the live state, with bits 11:0 reading zero. Reset clears every output to zero.
- R2: A successful completion lowers the remaining count by the bytes reported, limited to the requested length. A failed completion leaves count, offset, page index and toggle unchanged, and the same request is issued again in the next cycle.
- R3: A descriptor loaded with a zero byte count issues exactly one request of length zero. Its successful completion retires the descriptor.
- R4: Every request length is the smaller of the maximum packet size and the remaining count. For an OUT transfer this makes the last request carry the remainder.
- R5: The request address is the selected page frame number times 4096 plus the current offset. After a success the offset advances by the moved bytes modulo 4096, and the page index rises by one when a 4 KB boundary is passed.
- R6: A load with a byte count above 0x5000 or a page index above 4 is rejected. `load_err` pulses for one cycle after the load and the block stays inactive.
- R7: `req_toggle` presents the current data toggle. The toggle inverts after each successful completion and never after a failed one.
- R8: When a descriptor with interrupt-on-complete retires, an interrupt is held pending. `irq` pulses for one cycle, in the cycle after the next `thresh_tick` that follows the retirement. A descriptor without the flag raises no interrupt.
- R9: On an IN transfer, a successful completion with fewer bytes than requested retires the descriptor at once.
- R10: A load presented while a descriptor is active is ignored. After retirement no request is issued until a new load is accepted.
- R11: `req_valid` stays high until `req_ready`. A completion is only taken after a request has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_valid | input | 1 | Load a new descriptor (taken only while inactive) |
| load_token | input | 32 | Token word |
| load_offset | input | 12 | Starting offset in the first page |
| load_pages | input | PAGES*20 | Page frame numbers, entry i at bits [20i+19:20i] |
| load_mps | input | MPS_W | Maximum packet size in bytes (at least 1) |
| load_is_in | input | 1 | 1 for an IN transfer, 0 for OUT |
| load_err | output | 1 | One-cycle pulse for a refused load |
| active | output | 1 | A descriptor is being executed |
| req_valid | output | 1 | Transaction request present |
| req_ready | input | 1 | Request accepted by the bus engine |
| req_addr | output | 32 | Buffer address of the request |
| req_len | output | 15 | Byte length of the request |
| req_toggle | output | 1 | DATA0 (0) or DATA1 (1) for the request |
| cmp_valid | input | 1 | Completion of the accepted request |
| cmp_ok | input | 1 | Completion succeeded |
| cmp_bytes | input | 15 | Bytes actually moved |
| thresh_tick | input | 1 | Interrupt threshold tick |
| irq | output | 1 | Completion interrupt pulse |
| token_out | output | 32 | Live token word |

## Verification
The bench builds the block with five pages, a 0x5000 byte limit and an 11-bit packet size field, so that packet sizes of 64, 128 and 1024 can be used. With these values one transfer runs through the full five-page buffer and ends with the page index at 5. Another transfer starts 256 bytes before a page end, so its requests span a page boundary. Both refusal limits, a zero-length descriptor and an early short IN packet are also reachable within a few hundred cycles.

// File: rtl/td_xfer_pkg.sv
// Shared constants for the transfer descriptor sequencer.
// Assumes the fixed 32-bit token layout: toggle, byte count, interrupt flag, page index.
package td_xfer_pkg;
    localparam int TOK_TOG  = 31;
    localparam int CNT_HI   = 30;
    localparam int CNT_LO   = 16;
    localparam int TOK_IOC  = 15;
    localparam int IDX_HI   = 14;
    localparam int IDX_LO   = 12;
    localparam int CNT_W    = CNT_HI - CNT_LO + 1;
    localparam int IDX_W    = IDX_HI - IDX_LO + 1;
    localparam int OFF_W    = 12;

    typedef enum logic {PH_REQ = 1'b0, PH_WAIT = 1'b1} phase_t;
endpackage

// File: rtl/td_xfer_addr.sv
// Request builder: chooses the page frame from the current index and forms the address and length.
// Assumes the offset is below 4096 and the page index is below PAGES while a request is shown.
module td_xfer_addr
    import td_xfer_pkg::*;
#(
    parameter int PAGES     = 5,
    parameter int PAGE_BITS = 20,
    parameter int MPS_W     = 11
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       show,
    input  logic [PAGES*PAGE_BITS-1:0] pg_flat,
    input  logic [IDX_W-1:0]           idx,
    input  logic [OFF_W-1:0]           off,
    input  logic [CNT_W-1:0]           rem,
    input  logic [MPS_W-1:0]           mps,
    output logic [PAGE_BITS+OFF_W-1:0] addr,
    output logic [CNT_W-1:0]           len
);
    logic [PAGE_BITS-1:0] sel_pg;
    logic [CNT_W-1:0]     mps_ext;

    // Select the page frame named by the page index.
    always_comb begin
        sel_pg = '0;
        for (int i = 0; i < PAGES; i++) begin
            if (idx == IDX_W'(i)) sel_pg = pg_flat[i*PAGE_BITS +: PAGE_BITS];
        end
    end

    // Length is the smaller of the packet size and the remaining count.
    always_comb begin
        mps_ext = CNT_W'(mps);
        len     = (mps_ext < rem) ? mps_ext : rem;
        addr    = {sel_pg, off};
    end

    // R4: a request never exceeds the packet size or the remaining count.
    a_r4_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
        show |-> (len <= rem) && (len <= CNT_W'(mps)));
endmodule

// File: rtl/td_xfer_irq.sv
// Completion interrupt holder: keeps a retirement pending and releases it on the next threshold tick.
// Assumes retire_ioc is a single-cycle pulse.
module td_xfer_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic retire_ioc,
    input  logic tick,
    output logic irq
);
    logic pend_q;

    // Set pending on a flagged retirement, clear it when a tick releases it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            irq    <= 1'b0;
        end else begin
            irq <= tick && pend_q;
            if (retire_ioc)  pend_q <= 1'b1;
            else if (tick)   pend_q <= 1'b0;
        end
    end

    // R8: an interrupt pulse always follows a threshold tick.
    a_r8_irq_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(tick));
    // R8: the pulse lasts one cycle unless a new retirement refilled it.
    a_r8_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !$past(retire_ioc) |=> !irq);
endmodule

// File: rtl/td_xfer_ctrl.sv
// Descriptor state and transaction sequencing: load checks, request/wait phases and progress update.
// Assumes the packet size is at least 1 and below 4096, so one completion crosses at most one page.
module td_xfer_ctrl
    import td_xfer_pkg::*;
#(
    parameter int PAGES     = 5,
    parameter int PAGE_BITS = 20,
    parameter int MPS_W     = 11,
    parameter int MAX_BYTES = 'h5000
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load_valid,
    input  logic [31:0]                load_token,
    input  logic [OFF_W-1:0]           load_offset,
    input  logic [PAGES*PAGE_BITS-1:0] load_pages,
    input  logic [MPS_W-1:0]           load_mps,
    input  logic                       load_is_in,
    input  logic                       req_ready,
    input  logic                       cmp_valid,
    input  logic                       cmp_ok,
    input  logic [CNT_W-1:0]           cmp_bytes,
    input  logic [CNT_W-1:0]           cur_len,
    output logic                       active_q,
    output logic                       req_show,
    output logic [PAGES*PAGE_BITS-1:0] pg_q,
    output logic [IDX_W-1:0]           idx_q,
    output logic [OFF_W-1:0]           off_q,
    output logic [CNT_W-1:0]           rem_q,
    output logic [MPS_W-1:0]           mps_q,
    output logic                       tog_q,
    output logic                       ioc_q,
    output logic                       load_err,
    output logic                       retire_ioc
);
    localparam int SUM_W = OFF_W + 1;

    phase_t             ph_q;
    logic               in_q;
    logic               take, bad, done_ok, short_pkt, retire;
    logic [CNT_W-1:0]   moved, rem_nx;
    logic [SUM_W-1:0]   off_sum;

    // Load screening and completion arithmetic.
    always_comb begin
        take      = load_valid && !active_q;
        bad       = (load_token[CNT_HI:CNT_LO] > CNT_W'(MAX_BYTES)) ||
                    (load_token[IDX_HI:IDX_LO] >= IDX_W'(PAGES));
        done_ok   = active_q && (ph_q == PH_WAIT) && cmp_valid && cmp_ok;
        moved     = (cmp_bytes > cur_len) ? cur_len : cmp_bytes;
        rem_nx    = rem_q - moved;
        off_sum   = SUM_W'(off_q) + SUM_W'(moved);
        short_pkt = in_q && (moved < cur_len);
        retire    = done_ok && ((rem_nx == '0) || short_pkt);
        req_show  = active_q && (ph_q == PH_REQ);
        retire_ioc = retire && ioc_q;
    end

    // Descriptor registers, phase sequencing and progress update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            ph_q     <= PH_REQ;
            pg_q     <= '0;
            idx_q    <= '0;
            off_q    <= '0;
            rem_q    <= '0;
            mps_q    <= '0;
            tog_q    <= 1'b0;
            ioc_q    <= 1'b0;
            in_q     <= 1'b0;
            load_err <= 1'b0;
        end else begin
            load_err <= take && bad;
            if (take && !bad) begin
                active_q <= 1'b1;
                ph_q     <= PH_REQ;
                pg_q     <= load_pages;
                idx_q    <= load_token[IDX_HI:IDX_LO];
                off_q    <= load_offset;
                rem_q    <= load_token[CNT_HI:CNT_LO];
                mps_q    <= load_mps;
                tog_q    <= load_token[TOK_TOG];
                ioc_q    <= load_token[TOK_IOC];
                in_q     <= load_is_in;
            end else if (req_show && req_ready) begin
                ph_q <= PH_WAIT;
            end else if (active_q && ph_q == PH_WAIT && cmp_valid) begin
                ph_q <= PH_REQ;
                if (cmp_ok) begin
                    rem_q <= rem_nx;
                    off_q <= off_sum[OFF_W-1:0];
                    idx_q <= idx_q + IDX_W'(off_sum[OFF_W]);
                    tog_q <= ~tog_q;
                    if (retire) active_q <= 1'b0;
                end
            end
        end
    end

    // R2: a failed completion keeps the progress state and returns to the request phase.
    a_r2_fail_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && ph_q == PH_WAIT && cmp_valid && !cmp_ok) |=>
        ($stable(rem_q) && $stable(off_q) && $stable(idx_q) && $stable(tog_q) && req_show));
    // R7: the toggle inverts after every success.
    a_r7_toggle_flip: assert property (@(posedge clk) disable iff (!rst_n)
        done_ok |=> (tog_q != $past(tog_q)));
    // R10: a load during an active descriptor changes nothing that was captured.
    a_r10_load_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && load_valid) |=> ($stable(mps_q) && $stable(pg_q)));
    // R6: a refused load never starts the block.
    a_r6_err_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        load_err |-> !active_q);
    // R11: a waiting request stays presented.
    a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req_show && !req_ready && !(load_valid && !active_q)) |=> req_show);
endmodule

// File: rtl/td_xfer_seq.sv
// Top of the transfer descriptor sequencer: ties the state controller, request builder and interrupt holder.
// Assumes the bus engine returns exactly one completion per accepted request.
module td_xfer_seq
    import td_xfer_pkg::*;
#(
    parameter int PAGES     = 5,
    parameter int PAGE_BITS = 20,
    parameter int MPS_W     = 11,
    parameter int MAX_BYTES = 'h5000
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load_valid,
    input  logic [31:0]                load_token,
    input  logic [OFF_W-1:0]           load_offset,
    input  logic [PAGES*PAGE_BITS-1:0] load_pages,
    input  logic [MPS_W-1:0]           load_mps,
    input  logic                       load_is_in,
    output logic                       load_err,
    output logic                       active,
    output logic                       req_valid,
    input  logic                       req_ready,
    output logic [PAGE_BITS+OFF_W-1:0] req_addr,
    output logic [CNT_W-1:0]           req_len,
    output logic                       req_toggle,
    input  logic                       cmp_valid,
    input  logic                       cmp_ok,
    input  logic [CNT_W-1:0]           cmp_bytes,
    input  logic                       thresh_tick,
    output logic                       irq,
    output logic [31:0]                token_out
);
    logic [PAGES*PAGE_BITS-1:0] pg_q;
    logic [IDX_W-1:0]           idx_q;
    logic [OFF_W-1:0]           off_q;
    logic [CNT_W-1:0]           rem_q;
    logic [MPS_W-1:0]           mps_q;
    logic                       tog_q, ioc_q, retire_ioc;

    td_xfer_ctrl #(.PAGES(PAGES), .PAGE_BITS(PAGE_BITS), .MPS_W(MPS_W), .MAX_BYTES(MAX_BYTES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_token(load_token),
        .load_offset(load_offset), .load_pages(load_pages), .load_mps(load_mps),
        .load_is_in(load_is_in), .req_ready(req_ready), .cmp_valid(cmp_valid),
        .cmp_ok(cmp_ok), .cmp_bytes(cmp_bytes), .cur_len(req_len), .active_q(active),
        .req_show(req_valid), .pg_q(pg_q), .idx_q(idx_q), .off_q(off_q), .rem_q(rem_q),
        .mps_q(mps_q), .tog_q(tog_q), .ioc_q(ioc_q), .load_err(load_err),
        .retire_ioc(retire_ioc)
    );

    td_xfer_addr #(.PAGES(PAGES), .PAGE_BITS(PAGE_BITS), .MPS_W(MPS_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .show(req_valid), .pg_flat(pg_q), .idx(idx_q),
        .off(off_q), .rem(rem_q), .mps(mps_q), .addr(req_addr), .len(req_len)
    );

    td_xfer_irq u_irq (
        .clk(clk), .rst_n(rst_n), .retire_ioc(retire_ioc), .tick(thresh_tick), .irq(irq)
    );

    // Present the live token word and the current toggle.
    always_comb begin
        req_toggle = tog_q;
        token_out  = {tog_q, rem_q, ioc_q, idx_q, {OFF_W{1'b0}}};
    end
endmodule

// File: tb/td_xfer_seq_tb.sv
module td_xfer_seq_tb;
    localparam int PAGES = 5;
    localparam int PB    = 20;
    localparam int MPS_W = 11;

    logic clk = 1'b0, rst_n = 1'b0;
    logic load_valid = 0, load_is_in = 0, req_ready = 0, cmp_valid = 0, cmp_ok = 0, thresh_tick = 0;
    logic [31:0] load_token = '0;
    logic [11:0] load_offset = '0;
    logic [PAGES*PB-1:0] load_pages = '0;
    logic [MPS_W-1:0] load_mps = '0;
    logic [14:0] cmp_bytes = '0;
    logic load_err, active, req_valid, req_toggle, irq;
    logic [31:0] req_addr, token_out;
    logic [14:0] req_len;

    int checks = 0, fails = 0, cyc = 0, irq_seen = 0;
    bit cmp_en = 0, done = 0;

    // behavioural reference state
    int m_act, m_ph, m_rem, m_off, m_idx, m_tog, m_ioc, m_in, m_mps, m_pend, m_irq, m_err;
    int m_pg[PAGES];

    td_xfer_seq u_dut (
        .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_token(load_token),
        .load_offset(load_offset), .load_pages(load_pages), .load_mps(load_mps),
        .load_is_in(load_is_in), .load_err(load_err), .active(active), .req_valid(req_valid),
        .req_ready(req_ready), .req_addr(req_addr), .req_len(req_len), .req_toggle(req_toggle),
        .cmp_valid(cmp_valid), .cmp_ok(cmp_ok), .cmp_bytes(cmp_bytes),
        .thresh_tick(thresh_tick), .irq(irq), .token_out(token_out)
    );

    always #5 clk = ~clk;

    function automatic int m_len();
        return (m_mps < m_rem) ? m_mps : m_rem;
    endfunction

    task automatic check(string r, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", r, act, exp, cyc);
        end
    endtask

    // Reference model update on each rising edge.
    always @(posedge clk) begin
        int mv, rl, s, ret;
        cyc++;
        if (!rst_n) begin
            m_act = 0; m_ph = 0; m_rem = 0; m_off = 0; m_idx = 0; m_tog = 0; m_ioc = 0;
            m_in = 0; m_mps = 0; m_pend = 0; m_irq = 0; m_err = 0;
            foreach (m_pg[i]) m_pg[i] = 0;
        end else begin
            ret = 0;
            m_err = 0;
            m_irq = (thresh_tick && m_pend) ? 1 : 0;
            if (!m_act) begin
                if (load_valid) begin
                    if (load_token[30:16] > 15'h5000 || load_token[14:12] > 4) m_err = 1;
                    else begin
                        m_act = 1; m_ph = 0; m_rem = load_token[30:16]; m_idx = load_token[14:12];
                        m_tog = load_token[31]; m_ioc = load_token[15]; m_off = load_offset;
                        m_mps = load_mps; m_in = load_is_in;
                        foreach (m_pg[i]) m_pg[i] = load_pages[i*PB +: PB];
                    end
                end
            end else if (m_ph == 0) begin
                if (req_ready) m_ph = 1;
            end else if (cmp_valid) begin
                if (!cmp_ok) m_ph = 0;
                else begin
                    rl = m_len(); mv = cmp_bytes; if (mv > rl) mv = rl;
                    m_rem -= mv; s = m_off + mv;
                    if (s >= 4096) begin m_idx++; s -= 4096; end
                    m_off = s; m_tog ^= 1;
                    if (m_rem == 0 || (m_in && mv < rl)) begin m_act = 0; ret = m_ioc; end
                    else m_ph = 0;
                end
            end
            if (ret) m_pend = 1; else if (thresh_tick) m_pend = 0;
        end
    end

    // Compare every output with the model between edges.
    always @(negedge clk) begin
        if (cmp_en) begin
            check("R10 active", active, m_act);
            check("R11 req_valid", req_valid, m_act && m_ph == 0);
            if (m_act && m_ph == 0) begin
                check("R5 req_addr", req_addr, m_pg[m_idx] * 4096 + m_off);
                check("R4 req_len", req_len, m_len());
                check("R7 req_toggle", req_toggle, m_tog);
            end
            check("R1 token_out", token_out,
                  (longint'(m_tog) << 31) | (longint'(m_rem) << 16) | (longint'(m_ioc) << 15) | (longint'(m_idx) << 12));
            check("R8 irq", irq, m_irq);
            check("R6 load_err", load_err, m_err);
            if (irq) irq_seen++;
        end
    end

    function automatic logic [31:0] tok(int tg, int tot, int ioc, int ix);
        return {tg[0], tot[14:0], ioc[0], ix[2:0], 12'h000};
    endfunction

    task automatic load(logic [31:0] t, int off, int mps, int is_in);
        @(negedge clk);
        load_valid = 1; load_token = t; load_offset = off[11:0]; load_mps = mps[MPS_W-1:0];
        load_is_in = is_in[0];
        @(negedge clk);
        load_valid = 0;
    endtask

    task automatic txn(int ok, int bytes);
        int n = 0;
        while (!req_valid && n < 50) begin @(negedge clk); n++; end
        req_ready = 1;
        cmp_bytes = (bytes < 0) ? req_len : bytes[14:0];
        @(negedge clk);
        req_ready = 0; cmp_valid = 1; cmp_ok = ok[0];
        @(negedge clk);
        cmp_valid = 0;
    endtask

    task automatic run_all();
        int n = 0;
        while (active && n < 100) begin txn(1, -1); n++; end
    endtask

    task automatic tick();
        @(negedge clk); thresh_tick = 1; @(negedge clk); thresh_tick = 0;
    endtask

    initial begin
        for (int i = 0; i < PAGES; i++) load_pages[i*PB +: PB] = 20'h10000 + 20'(i * 3 + 1);
        repeat (3) @(negedge clk);
        rst_n = 1;
        cmp_en = 1;
        // R1: reset state
        check("R1 reset token", token_out, 0);
        check("R1 reset active", active, 0);
        // R4 R5 R2 R10: OUT 1000 bytes, 64-byte packets, crossing a page
        load(tok(1, 1000, 0, 0), 'hF00, 64, 0);
        txn(1, -1); txn(1, -1);
        txn(0, 0);                               // R2 failed transaction
        load(tok(0, 40, 1, 3), 0, 8, 0);          // R10 ignored while active
        run_all();
        check("R4 last OUT remainder done", token_out[30:16], 0);
        check("R5 page advanced", token_out[14:12], 1);
        req_ready = 1; repeat (4) @(negedge clk); req_ready = 0;   // R10 no requests while idle
        check("R8 no irq without flag", irq_seen, 0);
        // R3 R8: zero-length with interrupt flag
        load(tok(0, 0, 1, 2), 'h10, 64, 0);
        check("R3 zero-length request", req_len, 0);
        txn(1, 0);
        check("R3 retired after zero-length", active, 0);
        repeat (3) @(negedge clk);
        check("R8 irq held pending", irq_seen, 0);
        tick();
        @(negedge clk);
        check("R8 irq after tick", irq_seen, 1);
        // R6: refused loads
        load(tok(0, 'h5001, 0, 0), 0, 64, 0);
        check("R6 oversize inactive", active, 0);
        load(tok(0, 10, 0, 5), 0, 64, 0);
        check("R6 bad index inactive", active, 0);
        // R9: IN short packet
        load(tok(1, 300, 1, 1), 'h20, 128, 1);
        txn(1, -1); txn(1, 50);
        check("R9 short retires", active, 0);
        check("R9 remaining", token_out[30:16], 300 - 178);
        tick(); @(negedge clk);
        check("R8 second irq", irq_seen, 2);
        // R5: full five-page transfer with 1024-byte packets
        load(tok(0, 'h5000, 0, 0), 0, 1024, 0);
        run_all();
        check("R5 five-page token", token_out, 32'h0000_5000);
        tick(); @(negedge clk);
        check("R8 no irq for plain descriptor", irq_seen, 2);
        repeat (3) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog ends a hung run as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule